// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

A register-mapped timer peripheral with two or three independent down-counting channels. All the channels share one run register: each bit of it lets one channel count. Each channel has a reload value, a live counter and a control word. The control word holds a count-clock divisor select, a sticky underflow flag and an interrupt enable. Each channel has its own interrupt line.

Software arms an interval in three steps. It stops the channel, writes the counter and the reload value, and then sets the channel's run bit. On each prescaled tick the counter steps down by one. On the tick that finds it at zero, it reloads and raises the flag. The flag stays set until software writes the control word with the flag bit at zero. If the reload value is left at all ones, the channel runs free, and the inverted counter gives a steadily rising timestamp.

Register access is a plain synchronous bus. A write takes effect at the clock edge on which it is presented. Read data is a combinational function of the address. There is no streaming data path, so the bus carries no valid/ready handshake and applies no back-pressure.

Top module: `tmr_unit`

## Requirements
- R1: After reset the run register reads 0, every counter and every reload register reads 0xFFFFFFFF, every control word reads 0 and every interrupt line is low.
- R2: The run register is at byte address 4, or at address 2 when ALT_MAP=1. Bit n lets channel n count. Bits for channels that are not implemented ignore writes and read as 0; with three channels, writing 0xFF reads back 0x07.
- R3: Channel n's reload register is at 8+12n, its counter at 12+12n and its control word at 16+12n. With ALT_MAP=1 all three addresses are 4 lower. The control word holds the divisor code in bits [2:0], the interrupt enable in bit 5 and the flag in bit 8. All its other bits read 0.
- R4: Divisor codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks. Codes 5, 6 and 7 behave as code 0.
- R5: A channel's prescaler restarts whenever the channel is stopped. The first decrement lands at the 4th edge after the edge that sets the run bit when the divisor is 4 (in general, at the divisor-th edge).
- R6: A running channel decrements by one on each tick. A stopped channel holds its count. Inverting a free-running count gives a rising value.
- R7: On a tick that finds the counter at 0, the counter loads the reload register and the flag is set on the same edge.
- R8: A control-word write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves the flag unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R9: A channel's interrupt line is high exactly when its flag and its enable are both 1.
- R10: A bus write to a counter takes priority over a decrement on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
A register write lands on the edge it is presented at, so its effect is visible at the next falling edge. Bus reads are combinational, and the bench samples them one time unit after it sets the address at a falling edge. A decrement, reload or flag change caused by a tick appears at the falling edge after that tick's rising edge, and the interrupt lines follow in the same half cycle. A behavioural model updated on every rising edge predicts all of this, and every falling edge compares all interrupt lines and each bus read with the model. Literal values are also checked where the elapsed tick count is fixed by construction: the prescaler start latency, the divisor lengths and the write-over-decrement priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PCNT_W    = 10;
  localparam int CTL_W     = 16;
  localparam int CTL_IE    = 5;
  localparam int CTL_FLAG  = 8;

  typedef enum logic [2:0] {
    PSC_4    = 3'd0,
    PSC_16   = 3'd1,
    PSC_64   = 3'd2,
    PSC_256  = 3'd3,
    PSC_1024 = 3'd4
  } psc_code_e;

  function automatic logic [PCNT_W-1:0] psc_last(input logic [2:0] code);
    case (code)
      PSC_16:   psc_last = PCNT_W'(15);
      PSC_64:   psc_last = PCNT_W'(63);
      PSC_256:  psc_last = PCNT_W'(255);
      PSC_1024: psc_last = PCNT_W'(1023);
      default:  psc_last = PCNT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] last;

  assign last = psc_last(code);
  assign tick = run && (pcnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_addr_map.sv
module tmr_addr_map #(
  parameter int NUM_CH  = 3,
  parameter int ALT_MAP = 0,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output logic [NUM_CH-1:0] rel_hit,
  output logic [NUM_CH-1:0] cnt_hit,
  output logic [NUM_CH-1:0] ctl_hit
);
  localparam int START_OFS = (ALT_MAP != 0) ? 2 : 4;
  localparam int BASE_OFS  = (ALT_MAP != 0) ? 4 : 8;
  localparam int CH_STRIDE = 12;

  assign start_hit = (addr == ADDR_W'(START_OFS));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int B = BASE_OFS + CH_STRIDE * n;
    assign rel_hit[n] = (addr == ADDR_W'(B));
    assign cnt_hit[n] = (addr == ADDR_W'(B + 4));
    assign ctl_hit[n] = (addr == ADDR_W'(B + 8));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rel_we,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rel_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             flag_q,
  output logic             ie_q,
  output logic             tick,
  output logic             irq
);
  logic [2:0] psc_q;
  logic       undf;
  logic       unused_bits;

  assign unused_bits = ^{wdata[CNT_W-1:CTL_FLAG+1], wdata[CTL_FLAG-1:CTL_IE+1], wdata[CTL_IE-1:3]};

  tmr_prescale u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (psc_q),
    .tick (tick)
  );

  assign undf = tick && (cnt_q == '0) && !cnt_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (tick) begin
      cnt_q <= (cnt_q == '0) ? rel_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rel_q <= '1;
    else if (rel_we) rel_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        psc_q <= wdata[2:0];
        ie_q  <= wdata[CTL_IE];
      end
      if (undf)        flag_q <= 1'b1;
      else if (ctl_we) flag_q <= flag_q & wdata[CTL_FLAG];
    end
  end

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[2:0]      = psc_q;
    ctl_rd[CTL_IE]   = ie_q;
    ctl_rd[CTL_FLAG] = flag_q;
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ALT_MAP = 0,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic              start_hit;
  logic [NUM_CH-1:0] rel_hit, cnt_hit, ctl_hit;
  logic [NUM_CH-1:0] rel_we, cnt_we, ctl_we;
  logic [NUM_CH-1:0] start_q;
  logic [NUM_CH-1:0] ch_flag, ch_ie, ch_tick;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_rel, ch_cnt;
  logic [NUM_CH-1:0][CTL_W-1:0] ch_ctl;

  tmr_addr_map #(.NUM_CH(NUM_CH), .ALT_MAP(ALT_MAP), .ADDR_W(ADDR_W)) u_map (
    .addr     (bus_addr),
    .start_hit(start_hit),
    .rel_hit  (rel_hit),
    .cnt_hit  (cnt_hit),
    .ctl_hit  (ctl_hit)
  );

  assign rel_we = rel_hit & {NUM_CH{bus_we}};
  assign cnt_we = cnt_hit & {NUM_CH{bus_we}};
  assign ctl_we = ctl_hit & {NUM_CH{bus_we}};

  always_ff @(posedge clk) begin
    if (!rst_n)                  start_q <= '0;
    else if (bus_we && start_hit) start_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start_q[n]),
      .rel_we(rel_we[n]),
      .cnt_we(cnt_we[n]),
      .ctl_we(ctl_we[n]),
      .wdata (bus_wdata),
      .rel_q (ch_rel[n]),
      .cnt_q (ch_cnt[n]),
      .ctl_rd(ch_ctl[n]),
      .flag_q(ch_flag[n]),
      .ie_q  (ch_ie[n]),
      .tick  (ch_tick[n]),
      .irq   (irq[n])
    );
  end

  always_comb begin
    bus_rdata = start_hit ? CNT_W'(start_q) : '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (rel_hit[n]) bus_rdata = bus_rdata | ch_rel[n];
      if (cnt_hit[n]) bus_rdata = bus_rdata | ch_cnt[n];
      if (ctl_hit[n]) bus_rdata = bus_rdata | CNT_W'(ch_ctl[n]);
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CNT_W-1:0]         bus_wdata,
  input logic [NUM_CH-1:0]        start_q,
  input logic [NUM_CH-1:0]        cnt_we,
  input logic [NUM_CH-1:0]        ctl_we,
  input logic [NUM_CH-1:0]        ch_tick,
  input logic [NUM_CH-1:0]        ch_flag,
  input logic [NUM_CH-1:0]        ch_ie,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0]        irq
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    // R6
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[n] && !cnt_we[n]) |=> $stable(ch_cnt[n]));
    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[n] && !cnt_we[n] && ch_cnt[n] != '0) |=> ch_cnt[n] == $past(ch_cnt[n]) - 1'b1);
    // R7
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[n] && !cnt_we[n] && ch_cnt[n] == '0) |=> ch_flag[n]);
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we[n] |=> ch_cnt[n] == $past(bus_wdata));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_flag[n] && !(ctl_we[n] && !bus_wdata[8])) |=> ch_flag[n]);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_ie[n] || !ch_flag[n]) |-> !irq[n]);
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wdata(bus_wdata),
  .start_q  (start_q),
  .cnt_we   (cnt_we),
  .ctl_we   (ctl_we),
  .ch_tick  (ch_tick),
  .ch_flag  (ch_flag),
  .ch_ie    (ch_ie),
  .ch_cnt   (ch_cnt),
  .irq      (irq)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  localparam int NC = 3;
  localparam logic [7:0] A_START = 8'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] a_rel(int c); return 8'(8 + 12*c); endfunction
  function automatic logic [7:0] a_cnt(int c); return 8'(12 + 12*c); endfunction
  function automatic logic [7:0] a_ctl(int c); return 8'(16 + 12*c); endfunction

  // behavioural reference
  int          m_pc [NC];
  logic [31:0] m_cnt [NC];
  logic [31:0] m_rel [NC];
  logic [2:0]  m_psc [NC];
  logic        m_ie [NC];
  logic        m_flag [NC];
  logic [NC-1:0] m_start;

  function automatic int div_of(logic [2:0] c);
    case (c)
      3'd1: return 16;
      3'd2: return 64;
      3'd3: return 256;
      3'd4: return 1024;
      default: return 4;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = '0;
      for (int c = 0; c < NC; c++) begin
        m_pc[c] = 0; m_cnt[c] = '1; m_rel[c] = '1;
        m_psc[c] = 0; m_ie[c] = 0; m_flag[c] = 0;
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        bit tk, setf;
        tk = m_start[c] && (m_pc[c] >= div_of(m_psc[c]) - 1);
        setf = 0;
        m_pc[c] = (!m_start[c] || tk) ? 0 : m_pc[c] + 1;
        if (bus_we && bus_addr == a_cnt(c)) m_cnt[c] = bus_wdata;
        else if (tk) begin
          if (m_cnt[c] == 0) begin m_cnt[c] = m_rel[c]; setf = 1; end
          else m_cnt[c] = m_cnt[c] - 1;
        end
        if (bus_we && bus_addr == a_rel(c)) m_rel[c] = bus_wdata;
        if (bus_we && bus_addr == a_ctl(c)) begin
          m_psc[c] = bus_wdata[2:0];
          m_ie[c] = bus_wdata[5];
          m_flag[c] = (m_flag[c] & bus_wdata[8]) | setf;
        end else m_flag[c] = m_flag[c] | setf;
      end
      if (bus_we && bus_addr == A_START) m_start = bus_wdata[NC-1:0];
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == A_START) return 32'(m_start);
    for (int c = 0; c < NC; c++) begin
      if (a == a_rel(c)) return m_rel[c];
      if (a == a_cnt(c)) return m_cnt[c];
      if (a == a_ctl(c)) return {23'd0, m_flag[c], 2'd0, m_ie[c], 2'd0, m_psc[c]};
    end
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every cycle: interrupt lines against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NC-1:0] e;
      #1;
      for (int c = 0; c < NC; c++) e[c] = m_flag[c] & m_ie[c];
      check("R9 irq", 32'(irq), 32'(e));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, int waitn, logic [7:0] a, output logic [31:0] v);
    repeat (waitn) @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
    check(req, v, m_read(a));
  endtask

  task automatic rd_lit(string req, int waitn, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(req, waitn, a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_lit("R1 start", 0, A_START, 32'h0);
    rd_lit("R1 counter", 0, a_cnt(0), 32'hFFFF_FFFF);
    rd_lit("R1 reload", 0, a_rel(2), 32'hFFFF_FFFF);
    rd_lit("R1 control", 0, a_ctl(1), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 unimplemented run bits
    wr(A_START, 32'hFF);
    rd_lit("R2 run bits", 0, A_START, 32'h07);
    wr(A_START, 32'h0);

    // R3 control fields, flag write of 1 leaves it clear (R8)
    wr(a_ctl(1), 32'h0000_FFFF);
    rd_lit("R3 control fields", 0, a_ctl(1), 32'h0000_0027);
    wr(a_ctl(1), 32'h0);

    // R6 stopped channel holds
    wr(a_cnt(0), 32'd100);
    rd_lit("R6 hold", 30, a_cnt(0), 32'd100);

    // R5 first tick latency with divisor 4
    wr(a_cnt(0), 32'd10);
    wr(A_START, 32'h1);
    rd_lit("R5 before first tick", 2, a_cnt(0), 32'd10);
    rd_lit("R5 first tick", 2, a_cnt(0), 32'd9);

    // R7 underflow reload and flag, masked interrupt
    wr(a_rel(0), 32'd5);
    repeat (60) @(negedge clk);
    wr(A_START, 32'h0);
    rd("R7 counter after reload", 0, a_cnt(0), v1);
    rd_lit("R7 flag set", 0, a_ctl(0), 32'h0000_0100);
    check("R9 masked", 32'(irq), 32'h0);
    wr(a_ctl(0), 32'h0000_0120);
    rd_lit("R8 write one keeps flag", 0, a_ctl(0), 32'h0000_0120);
    check("R9 enabled", 32'(irq[0]), 32'h1);
    wr(a_ctl(0), 32'h0000_0020);
    rd_lit("R8 clear", 0, a_ctl(0), 32'h0000_0020);
    check("R9 cleared", 32'(irq[0]), 32'h0);

    // R4 divisors, literal tick counts
    wr(a_cnt(1), 32'd1000); wr(a_ctl(1), 32'd6); wr(A_START, 32'h2);
    rd_lit("R4 reserved code", 40, a_cnt(1), 32'd990);
    wr(A_START, 32'h0);
    wr(a_cnt(1), 32'd1000); wr(a_ctl(1), 32'd1); wr(A_START, 32'h2);
    rd_lit("R4 divide 16", 40, a_cnt(1), 32'd998);
    wr(A_START, 32'h0);
    wr(a_cnt(1), 32'd1000); wr(a_ctl(1), 32'd4); wr(A_START, 32'h2);
    rd_lit("R4 divide 1024", 2050, a_cnt(1), 32'd998);
    wr(A_START, 32'h0);
    for (int code = 0; code < 8; code++) begin
      wr(a_cnt(1), 32'd3); wr(a_rel(1), 32'd2);
      wr(a_ctl(1), 32'(code) | 32'h20); wr(A_START, 32'h2);
      rd("R4 code sweep", 300, a_cnt(1), v1);
      rd("R4 code sweep ctl", 0, a_ctl(1), v1);
      wr(A_START, 32'h0);
    end

    // R10 write wins over a decrement
    wr(a_ctl(2), 32'h0); wr(A_START, 32'h4);
    for (int k = 0; k < 8; k++) begin
      wr(a_cnt(2), 32'd77 + 32'(k));
      rd_lit("R10 write priority", 0, a_cnt(2), 32'd77 + 32'(k));
    end

    // R6 inverted free-running count rises
    wr(a_cnt(2), 32'h8000_0000);
    rd("R6 free run a", 3, a_cnt(2), v1);
    rd("R6 free run b", 10, a_cnt(2), v2);
    check("R6 rising inverted", 32'(~v1 < ~v2), 32'h1);

    // R8 clear writes at every phase of a running period
    wr(a_rel(0), 32'd2); wr(a_cnt(0), 32'd2); wr(a_ctl(0), 32'h20);
    wr(A_START, 32'h5);
    for (int k = 0; k < 16; k++) begin
      repeat (k % 5) @(negedge clk);
      wr(a_ctl(0), 32'h20);
      rd("R8 phase sweep", 0, a_ctl(0), v1);
    end
    wr(A_START, 32'h0);
    rd("R6 final", 2, a_cnt(0), v1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule